// File: doc/BRIEF.md
# Serial Control Register Write Receiver

This block takes write frames from a three-wire serial link (a serial clock, a data line and an active-low select). It stores the frames in a small bank of 16-bit control registers, and the rest of the device reads those registers. The three serial inputs are brought into the system clock domain through a synchronizer. Rising edges of the serial clock are then found by oversampling, so the serial clock may run at any rate that is slow enough to be seen. There is no lower limit on that rate.

Each frame carries 32 bits, most significant bit first:

- a 12-bit sync word,
- then a 4-bit register address,
- then a 16-bit value.

When the sync word is correct and the address names one of the nine implemented registers, the block does three things. It raises a one-cycle write strobe, it presents the decoded address and value, and it updates the register. Frames may follow each other while select stays low.

A status output stays high after reset until every implemented register has been written at least once. The whole receiver is gated by a control-mode enable input and by a power-down input. Neither input disturbs the stored values.

Top module: `ctrl_serial_rx`

## Requirements
- R1: A frame is 32 bits sampled on rising serial-clock edges while select is low, sent MSB first: bits 31..20 are the sync word, bits 19..16 the address, and bits 15..0 the value. The value appears in `cfg_regs[16*addr +: 16]`.
- R2: The sync word must be 12'h001 (eleven zeros, then a one; the first bit sent is 0). On a mismatch the frame is dropped with no strobe and no write. All further serial bits are then ignored until select has been seen high.
- R3: With select held low, the next frame begins on the 33rd rising serial-clock edge, and frames can follow back to back with no limit.
- R4: Select going high in the middle of a frame drops that frame, and the next frame counts from its first bit.
- R5: Only addresses 0, 1, 2, 3, 9, 10, 11, 14 and 15 are writable. A frame to any other address gives no strobe and no write, and those slots of `cfg_regs` always read zero.
- R6: Each accepted frame raises `wr_stb` for exactly one clock cycle, with `wr_addr` and `wr_data` holding the frame's address and value. The register takes the value on the following clock.
- R7: `init_pend` is 1 from reset until each of the nine writable registers has been written at least once, and is 0 after that.
- R8: While `ext_mode_en` is 0, serial traffic is ignored.
- R9: While `pwr_down` is 1, register contents are held unchanged and serial traffic is ignored.
- R10: Synchronous active-high `rst` clears every register to zero and sets `init_pend` to 1.
- R11: Frames are received correctly with each serial-clock phase lasting anywhere from 3 system clocks up to arbitrarily many.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode_en | input | 1 | Enables the serial receiver (control mode) |
| pwr_down | input | 1 | Power-down: receiver idle, registers held |
| sclk | input | 1 | Serial clock, asynchronous |
| sdata | input | 1 | Serial data, asynchronous |
| scs_n | input | 1 | Serial select, active low, asynchronous |
| wr_stb | output | 1 | One-cycle pulse per accepted frame |
| wr_addr | output | 4 | Address of the accepted frame |
| wr_data | output | 16 | Value of the accepted frame |
| init_pend | output | 1 | High until all nine registers have been written |
| cfg_regs | output | 256 | All 16 register slots, slot n at bits 16n+15..16n |

## Verification
A wrong bit count or a bad sync-word decision shows up on the next frame. The wrong slot of `cfg_regs` changes, or `wr_stb` appears when it should be absent (or is missing when it should appear), about four system clocks after the frame's last serial edge. A receiver stuck in its discard state shows up as a missing strobe on the first good frame after select returns high. Lost or extra "written" flags show up as `init_pend` falling too early or too late, within the same few cycles as the write that should decide it.

// File: rtl/ctrl_serial_pkg.sv
package ctrl_serial_pkg;

    localparam int HDR_W   = 12;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = HDR_W + ADDR_W + DATA_W;
    localparam int SLOTS   = 1 << ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    localparam logic [HDR_W-1:0] SYNC_WORD = 12'h001;

    // slots 0..3, 9..11, 14, 15 implemented
    localparam logic [SLOTS-1:0] DEFAULT_WR_MASK = 16'hCE0F;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HDR,
        RX_BODY,
        RX_SKIP
    } rx_state_e;

    function automatic wr_req_t split_frame(input logic [FRAME_W-1:0] word);
        wr_req_t r;
        r.addr = word[DATA_W +: ADDR_W];
        r.data = word[DATA_W-1:0];
        return r;
    endfunction

    function automatic logic slot_writable(input logic [SLOTS-1:0] mask,
                                           input logic [ADDR_W-1:0] a);
        return mask[a];
    endfunction

endpackage

// File: rtl/csr_in_sync.sv
module csr_in_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/csr_frame_rx.sv
module csr_frame_rx
    import ctrl_serial_pkg::*;
#(
    parameter logic [SLOTS-1:0] WR_MASK = DEFAULT_WR_MASK
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    sclk_s,
    input  logic    sdata_s,
    input  logic    scs_n_s,
    output logic    wr_valid,
    output wr_req_t wr_req
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);

    rx_state_e            state_q, state_n;
    logic [CNT_W-1:0]     cnt_q, cnt_n;
    logic [FRAME_W-2:0]   shift_q, shift_n;
    logic                 sclk_d;
    logic                 rise;
    logic                 active;
    logic                 fire;
    logic [FRAME_W-1:0]   full;
    logic [HDR_W-1:0]     hdr_now;
    wr_req_t              req_now;

    assign rise    = sclk_s & ~sclk_d;
    assign active  = enable & ~scs_n_s;
    assign full    = {shift_q, sdata_s};
    assign hdr_now = full[HDR_W-1:0];
    assign req_now = split_frame(full);

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        shift_n = shift_q;
        fire    = 1'b0;
        if (!active) begin
            state_n = RX_IDLE;
            cnt_n   = '0;
        end else if (state_q == RX_SKIP) begin
            state_n = RX_SKIP;
        end else if (rise) begin
            shift_n = full[FRAME_W-2:0];
            if (cnt_q == LAST_BIT) begin
                fire    = slot_writable(WR_MASK, req_now.addr);
                cnt_n   = '0;
                state_n = RX_HDR;
            end else if (cnt_q == HDR_LAST && hdr_now != SYNC_WORD) begin
                cnt_n   = '0;
                state_n = RX_SKIP;
            end else begin
                cnt_n   = cnt_q + 1'b1;
                state_n = (cnt_q >= HDR_LAST) ? RX_BODY : RX_HDR;
            end
        end else if (state_q == RX_IDLE) begin
            state_n = RX_HDR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RX_IDLE;
            cnt_q    <= '0;
            shift_q  <= '0;
            sclk_d   <= 1'b0;
            wr_valid <= 1'b0;
            wr_req   <= '0;
        end else begin
            state_q  <= state_n;
            cnt_q    <= cnt_n;
            shift_q  <= shift_n;
            sclk_d   <= sclk_s;
            wr_valid <= fire;
            if (fire) begin
                wr_req <= req_now;
            end
        end
    end

endmodule

// File: rtl/csr_reg_bank.sv
module csr_reg_bank
    import ctrl_serial_pkg::*;
#(
    parameter logic [SLOTS-1:0] WR_MASK = DEFAULT_WR_MASK
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_valid,
    input  wr_req_t                 wr_req,
    output logic [SLOTS*DATA_W-1:0] cfg_flat,
    output logic                    init_pend
);

    logic [SLOTS-1:0] done;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            if (WR_MASK[g]) begin : g_impl
                logic [DATA_W-1:0] val_q;
                logic              seen_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        val_q  <= '0;
                        seen_q <= 1'b0;
                    end else if (wr_valid && wr_req.addr == ADDR_W'(g)) begin
                        val_q  <= wr_req.data;
                        seen_q <= 1'b1;
                    end
                end
                assign cfg_flat[g*DATA_W +: DATA_W] = val_q;
                assign done[g] = seen_q;
            end else begin : g_resv
                assign cfg_flat[g*DATA_W +: DATA_W] = '0;
                assign done[g] = 1'b1;
            end
        end
    endgenerate

    assign init_pend = ~&done;

endmodule

// File: rtl/ctrl_serial_rx.sv
module ctrl_serial_rx
    import ctrl_serial_pkg::*;
#(
    parameter logic [SLOTS-1:0] WR_MASK     = DEFAULT_WR_MASK,
    parameter int               SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ext_mode_en,
    input  logic                    pwr_down,
    input  logic                    sclk,
    input  logic                    sdata,
    input  logic                    scs_n,
    output logic                    wr_stb,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [DATA_W-1:0]       wr_data,
    output logic                    init_pend,
    output logic [SLOTS*DATA_W-1:0] cfg_regs
);

    logic [2:0] pins_s;
    logic       rx_en;
    logic       wr_valid;
    wr_req_t    wr_req;

    csr_in_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scs_n, sdata, sclk}),
        .q   (pins_s)
    );

    assign rx_en = ext_mode_en & ~pwr_down;

    csr_frame_rx #(
        .WR_MASK (WR_MASK)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .enable   (rx_en),
        .sclk_s   (pins_s[0]),
        .sdata_s  (pins_s[1]),
        .scs_n_s  (pins_s[2]),
        .wr_valid (wr_valid),
        .wr_req   (wr_req)
    );

    csr_reg_bank #(
        .WR_MASK (WR_MASK)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_req    (wr_req),
        .cfg_flat  (cfg_regs),
        .init_pend (init_pend)
    );

    assign wr_stb  = wr_valid;
    assign wr_addr = wr_req.addr;
    assign wr_data = wr_req.data;

endmodule

// File: rtl/ctrl_serial_rx_chk.sv
module ctrl_serial_rx_chk
    import ctrl_serial_pkg::*;
#(
    parameter logic [SLOTS-1:0] WR_MASK = DEFAULT_WR_MASK
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ext_mode_en,
    input logic                    pwr_down,
    input logic                    wr_stb,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic                    init_pend,
    input logic [SLOTS*DATA_W-1:0] cfg_regs
);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    assert_addr_writable_R5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> WR_MASK[wr_addr]);

    assert_gated_mode_R8: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(ext_mode_en));

    assert_gated_pd_R9: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !$past(pwr_down));

    assert_hold_no_stb_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(cfg_regs));

    assert_init_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(init_pend) |-> $past(wr_stb));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (init_pend && cfg_regs == '0 && !wr_stb));

endmodule

bind ctrl_serial_rx ctrl_serial_rx_chk #(.WR_MASK(WR_MASK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_mode_en (ext_mode_en),
    .pwr_down    (pwr_down),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .init_pend   (init_pend),
    .cfg_regs    (cfg_regs)
);

// File: tb/ctrl_serial_rx_tb.sv
module ctrl_serial_rx_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ext_mode_en = 1'b1;
    logic         pwr_down = 1'b0;
    logic         sclk = 1'b0;
    logic         sdata = 1'b0;
    logic         scs_n = 1'b1;
    logic         wr_stb;
    logic [3:0]   wr_addr;
    logic [15:0]  wr_data;
    logic         init_pend;
    logic [255:0] cfg_regs;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    int dbl_cnt = 0;
    logic prev_stb = 1'b0;
    logic [3:0]  last_a = '0;
    logic [15:0] last_d = '0;
    logic [255:0] model = '0;
    logic [15:0]  seen = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    ctrl_serial_rx u_dut (
        .clk(clk), .rst(rst), .ext_mode_en(ext_mode_en), .pwr_down(pwr_down),
        .sclk(sclk), .sdata(sdata), .scs_n(scs_n), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .init_pend(init_pend),
        .cfg_regs(cfg_regs)
    );

    always @(posedge clk) begin
        if (wr_stb) begin
            stb_cnt++;
            last_a = wr_addr;
            last_d = wr_data;
            if (prev_stb) dbl_cnt++;
        end
        prev_stb = wr_stb;
    end

    // {addr, data}
    localparam int NVEC = 12;
    localparam logic [19:0] VEC [NVEC] = '{
        {4'h0, 16'hA5C3}, {4'h5, 16'h1234}, {4'h1, 16'h8001}, {4'h2, 16'hFFFF},
        {4'h3, 16'h7E18}, {4'hC, 16'hBEEF}, {4'h9, 16'h4C2D}, {4'hA, 16'h0101},
        {4'hB, 16'hF00F}, {4'hE, 16'h3C3C}, {4'h0, 16'h5555}, {4'hF, 16'h9AB7}
    };

    function automatic bit bw(input logic [3:0] a);
        case (a)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd9, 4'd10, 4'd11, 4'd14, 4'd15: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [3:0] a, input logic [15:0] d);
        if (bw(a)) begin
            model[int'(a)*16 +: 16] = d;
            seen[a] = 1'b1;
        end
    endtask

    task automatic sbit(input logic b, input int hp);
        @(negedge clk);
        sdata = b;
        sclk = 1'b0;
        repeat (hp) @(negedge clk);
        sclk = 1'b1;
        repeat (hp) @(negedge clk);
    endtask

    task automatic send(input logic [11:0] h, input logic [3:0] a, input logic [15:0] d,
                        input int hp, input int nbits);
        logic [31:0] w;
        w = {h, a, d};
        @(negedge clk);
        scs_n = 1'b0;
        for (int i = 31; i > 31 - nbits; i--) sbit(w[i], hp);
        @(negedge clk);
        sclk = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic sel_high;
        @(negedge clk);
        scs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R10 reset state
        check("R10 init_pend", 256'(init_pend), 256'(1));
        check("R10 cfg", cfg_regs, '0);
        check("R10 wr_stb", 256'(wr_stb), 256'(0));

        // table walk, select held low throughout (R3)
        s0 = stb_cnt;
        for (int i = 0; i < NVEC; i++) begin
            int sb;
            logic [3:0]  a;
            logic [15:0] d;
            a = VEC[i][19:16];
            d = VEC[i][15:0];
            sb = stb_cnt;
            send(12'h001, a, d, 4, 32);
            model_write(a, d);
            check("R1 cfg", cfg_regs, model);
            check("R5 strobe count", 256'(stb_cnt - sb), 256'(bw(a) ? 1 : 0));
            if (bw(a)) check("R6 addr/data", 256'({last_a, last_d}), 256'({a, d}));
            check("R7 init_pend", 256'(init_pend), 256'(seen != 16'hCE0F));
        end
        check("R3 back-to-back strobes", 256'(stb_cnt - s0), 256'(10));
        check("R6 single cycle", 256'(dbl_cnt), 256'(0));
        sel_high();

        // R2 bad sync word, then good frame while select still low
        s0 = stb_cnt;
        send(12'h003, 4'h1, 16'h1111, 4, 32);
        send(12'h001, 4'h1, 16'h2222, 4, 32);
        check("R2 discard cfg", cfg_regs, model);
        check("R2 discard strobe", 256'(stb_cnt - s0), 256'(0));
        sel_high();
        send(12'h801, 4'h2, 16'h3333, 4, 32);
        check("R2 first-bit-one cfg", cfg_regs, model);
        sel_high();
        send(12'h001, 4'h1, 16'h2222, 4, 32);
        model_write(4'h1, 16'h2222);
        check("R2 resync cfg", cfg_regs, model);
        sel_high();

        // R4 abort mid-frame
        send(12'h001, 4'h1, 16'h6666, 4, 20);
        sel_high();
        send(12'h001, 4'h2, 16'h7777, 4, 32);
        model_write(4'h2, 16'h7777);
        check("R4 abort", cfg_regs, model);
        sel_high();

        // R8 control mode off
        ext_mode_en = 1'b0;
        s0 = stb_cnt;
        send(12'h001, 4'h3, 16'hDEAD, 4, 32);
        sel_high();
        check("R8 ignored cfg", cfg_regs, model);
        check("R8 ignored strobe", 256'(stb_cnt - s0), 256'(0));
        ext_mode_en = 1'b1;

        // R9 power-down
        pwr_down = 1'b1;
        repeat (50) @(negedge clk);
        check("R9 retained", cfg_regs, model);
        send(12'h001, 4'h9, 16'hCAFE, 4, 32);
        sel_high();
        check("R9 ignored", cfg_regs, model);
        pwr_down = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 after wake", cfg_regs, model);

        // R11 slow and fast serial clock
        send(12'h001, 4'hA, 16'h1357, 40, 32);
        model_write(4'hA, 16'h1357);
        check("R11 slow", cfg_regs, model);
        send(12'h001, 4'hB, 16'h2468, 3, 32);
        model_write(4'hB, 16'h2468);
        check("R11 fast", cfg_regs, model);
        sel_high();

        // R5 reserved slot reads zero after a write attempt
        send(12'h001, 4'h7, 16'hFFFF, 4, 32);
        sel_high();
        check("R5 reserved zero", 256'(cfg_regs[7*16 +: 16]), 256'(0));

        // R10 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        model = '0;
        seen = '0;
        check("R10 cleared", cfg_regs, model);
        check("R10 init_pend again", 256'(init_pend), 256'(1));

        summary();
    end

endmodule